// File: doc/BRIEF.md
# Level-Compare GPIO Controller

This block is a memory-mapped general-purpose I/O controller for up to 32 pins, 16 by default. Each pin carries its own output value, direction, pull-up and pull-down enables, an alternate-function select, an interrupt enable and an interrupt polarity. The controller also models the resolved pad level from the block's own drive, an external driver and the pull enables. That level passes through a two-flop synchroniser and then feeds both the readable input register and the interrupt logic.

Interrupts are level comparisons, not edge detectors. A pin is pending while its synchronised level differs from its polarity bit and its enable bit is set. Pending pins are ORed into one summary line, which reaches `irq_o` only when the GPIO bit of a core-level mask register is set. To re-arm after service, software writes the current input value into the polarity bits. The pin then stays quiet until its level changes again. A reduced build with 5 pins is obtained by parameter.

Accesses use a flat 32-bit register port. A write is taken on the clock edge at which `reg_req_i` and `reg_we_i` are both high. Read data is a combinational function of `reg_addr_i`. Bits [1:0] of the address are ignored.

Top module: `gpio_pcmp_top`

## Requirements
- R1: Byte offsets are as follows: 0x00 input (read-only), 0x04 output data, 0x08 output enable, 0x0C alternate-function select, 0x10 pull-up, 0x14 pull-down, 0x18 interrupt enable, 0x1C polarity, 0x20 core mask (GPIO bit 0), 0x24 core status (read-only, bit 0 = GPIO summary). Bits at or above the pin count read 0 and ignore writes. Writes to read-only or unmapped offsets change nothing, and unmapped offsets read 0.
- R2: After reset, every register reads 0, every pad output is 0 and `irq_o` is low.
- R3: `pad_oe_o` and `pad_out_o` present the output-enable and output-data registers. A pin with output enable 1 has the resolved level of its output-data bit.
- R4: The input register shows the resolved pad level delayed by two clock edges, whatever the pin's direction. A driven pin therefore reads back its own output value.
- R5: An undriven pin (output enable 0) takes the following level, in priority order: `pad_in_i` when `pad_ext_en_i` is 1; otherwise 1 if its pull-up is set, even when its pull-down is also set; otherwise 0.
- R6: Pin i is pending when (input bit i XOR polarity bit i) AND enable bit i. The core status bit 0 is the OR of all pending pins, and pins with enable 0 never contribute.
- R7: `irq_o` is the core status summary ANDed with core mask bit 0.
- R8: Writing the current input value into the polarity bits clears the pending condition. It stays clear until the pin level changes, and then becomes pending again two edges later.
- R9: `alt_sel_o`, `pad_pu_o` and `pad_pd_o` present the alternate-function, pull-up and pull-down registers. The claim sequence (clear pull-down, set pull-up, clear alternate select) shows on these outputs.
- R10: With NUM_PINS = 5, only bits [4:0] of each per-pin register are writable and readable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_req_i | input | 1 | Register access request |
| reg_we_i | input | 1 | Write qualifier for the request |
| reg_addr_i | input | ADDR_W | Byte address |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data for `reg_addr_i` |
| pad_in_i | input | NUM_PINS | Level from an external driver |
| pad_ext_en_i | input | NUM_PINS | External driver active per pin |
| pad_out_o | output | NUM_PINS | Output data to pad |
| pad_oe_o | output | NUM_PINS | Output enable to pad |
| pad_pu_o | output | NUM_PINS | Pull-up enable |
| pad_pd_o | output | NUM_PINS | Pull-down enable |
| alt_sel_o | output | NUM_PINS | Alternate-function select |
| irq_o | output | 1 | Masked GPIO interrupt |

## Verification
The bench builds two instances side by side, one with the default 16 pins and one with 5 pins, and drives both with the same register traffic and pad stimulus. The 16-pin build exposes every pad-resolution case at once across its upper byte, where external drive, pull-up only, pull-down only and both pulls coexist. The 5-pin build shows that writes of all ones are truncated and that stimulus on wider pins never reaches the register file or the interrupt summary. Both instances run the interrupt cycle of arm, mask, re-arm by polarity write and re-fire on a level change.

// File: rtl/gpio_pcmp_pkg.sv
package gpio_pcmp_pkg;

  localparam int unsigned REG_W = 32;

  // word index = byte offset >> 2
  typedef enum logic [3:0] {
    RI_IN    = 4'd0,
    RI_DOUT  = 4'd1,
    RI_OE    = 4'd2,
    RI_ALT   = 4'd3,
    RI_PU    = 4'd4,
    RI_PD    = 4'd5,
    RI_IE    = 4'd6,
    RI_POL   = 4'd7,
    RI_CMASK = 4'd8,
    RI_CSTAT = 4'd9
  } reg_idx_e;

  localparam int unsigned CORE_GPIO_BIT = 0;

endpackage

// File: rtl/gpio_pcmp_pad.sv
module gpio_pcmp_pad #(
  parameter int unsigned NUM_PINS = 16
) (
  input  logic [NUM_PINS-1:0] dout_i,
  input  logic [NUM_PINS-1:0] oe_i,
  input  logic [NUM_PINS-1:0] pu_i,
  input  logic [NUM_PINS-1:0] pd_i,
  input  logic [NUM_PINS-1:0] ext_lvl_i,
  input  logic [NUM_PINS-1:0] ext_en_i,
  output logic [NUM_PINS-1:0] level_o
);

  for (genvar g = 0; g < NUM_PINS; g++) begin : g_pin
    always_comb begin
      if (oe_i[g])           level_o[g] = dout_i[g];
      else if (ext_en_i[g])  level_o[g] = ext_lvl_i[g];
      else if (pu_i[g])      level_o[g] = 1'b1;  // pull-up beats pull-down
      else if (pd_i[g])      level_o[g] = 1'b0;
      else                   level_o[g] = 1'b0;  // floating resolves low
    end
  end

endmodule

// File: rtl/gpio_pcmp_sync.sv
module gpio_pcmp_sync #(
  parameter int unsigned WIDTH  = 16,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);

  logic [WIDTH-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stage_q[s] <= '0;
        else         stage_q[s] <= d_i;
      end
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stage_q[s] <= '0;
        else         stage_q[s] <= stage_q[s-1];
      end
    end
  end

  assign q_o = stage_q[STAGES-1];

endmodule

// File: rtl/gpio_pcmp_irq.sv
module gpio_pcmp_irq #(
  parameter int unsigned NUM_PINS = 16
) (
  input  logic [NUM_PINS-1:0] level_i,
  input  logic [NUM_PINS-1:0] pol_i,
  input  logic [NUM_PINS-1:0] ie_i,
  output logic [NUM_PINS-1:0] pending_o,
  output logic                sum_o
);

  for (genvar g = 0; g < NUM_PINS; g++) begin : g_cmp
    assign pending_o[g] = (level_i[g] ^ pol_i[g]) & ie_i[g];
  end

  assign sum_o = |pending_o;

endmodule

// File: rtl/gpio_pcmp_regs.sv
module gpio_pcmp_regs
  import gpio_pcmp_pkg::*;
#(
  parameter int unsigned NUM_PINS = 16,
  parameter int unsigned ADDR_W   = 8
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                req_i,
  input  logic                we_i,
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic [REG_W-1:0]    wdata_i,
  output logic [REG_W-1:0]    rdata_o,
  input  logic [NUM_PINS-1:0] in_sync_i,
  input  logic                gpio_sum_i,
  output logic [NUM_PINS-1:0] dout_o,
  output logic [NUM_PINS-1:0] oe_o,
  output logic [NUM_PINS-1:0] alt_o,
  output logic [NUM_PINS-1:0] pu_o,
  output logic [NUM_PINS-1:0] pd_o,
  output logic [NUM_PINS-1:0] ie_o,
  output logic [NUM_PINS-1:0] pol_o,
  output logic                cmask_o
);

  localparam int unsigned IDX_W = ADDR_W - 2;

  logic [IDX_W-1:0]    widx;
  logic                wr_en;
  logic [NUM_PINS-1:0] wpins;

  assign widx  = addr_i[ADDR_W-1:2];
  assign wr_en = req_i & we_i;
  assign wpins = wdata_i[NUM_PINS-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dout_o  <= '0;
      oe_o    <= '0;
      alt_o   <= '0;
      pu_o    <= '0;
      pd_o    <= '0;
      ie_o    <= '0;
      pol_o   <= '0;
      cmask_o <= 1'b0;
    end else if (wr_en) begin
      case (widx)
        IDX_W'(RI_DOUT):  dout_o  <= wpins;
        IDX_W'(RI_OE):    oe_o    <= wpins;
        IDX_W'(RI_ALT):   alt_o   <= wpins;
        IDX_W'(RI_PU):    pu_o    <= wpins;
        IDX_W'(RI_PD):    pd_o    <= wpins;
        IDX_W'(RI_IE):    ie_o    <= wpins;
        IDX_W'(RI_POL):   pol_o   <= wpins;
        IDX_W'(RI_CMASK): cmask_o <= wdata_i[CORE_GPIO_BIT];
        default: ;  // input, status and holes are read-only
      endcase
    end
  end

  always_comb begin
    rdata_o = '0;
    case (widx)
      IDX_W'(RI_IN):    rdata_o = REG_W'(in_sync_i);
      IDX_W'(RI_DOUT):  rdata_o = REG_W'(dout_o);
      IDX_W'(RI_OE):    rdata_o = REG_W'(oe_o);
      IDX_W'(RI_ALT):   rdata_o = REG_W'(alt_o);
      IDX_W'(RI_PU):    rdata_o = REG_W'(pu_o);
      IDX_W'(RI_PD):    rdata_o = REG_W'(pd_o);
      IDX_W'(RI_IE):    rdata_o = REG_W'(ie_o);
      IDX_W'(RI_POL):   rdata_o = REG_W'(pol_o);
      IDX_W'(RI_CMASK): rdata_o[CORE_GPIO_BIT] = cmask_o;
      IDX_W'(RI_CSTAT): rdata_o[CORE_GPIO_BIT] = gpio_sum_i;
      default: ;
    endcase
  end

endmodule

// File: rtl/gpio_pcmp_top.sv
module gpio_pcmp_top
  import gpio_pcmp_pkg::*;
#(
  parameter int unsigned NUM_PINS    = 16,
  parameter int unsigned ADDR_W      = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                reg_req_i,
  input  logic                reg_we_i,
  input  logic [ADDR_W-1:0]   reg_addr_i,
  input  logic [31:0]         reg_wdata_i,
  output logic [31:0]         reg_rdata_o,
  input  logic [NUM_PINS-1:0] pad_in_i,
  input  logic [NUM_PINS-1:0] pad_ext_en_i,
  output logic [NUM_PINS-1:0] pad_out_o,
  output logic [NUM_PINS-1:0] pad_oe_o,
  output logic [NUM_PINS-1:0] pad_pu_o,
  output logic [NUM_PINS-1:0] pad_pd_o,
  output logic [NUM_PINS-1:0] alt_sel_o,
  output logic                irq_o
);

  logic [NUM_PINS-1:0] pad_level;
  logic [NUM_PINS-1:0] in_sync;
  logic [NUM_PINS-1:0] ie;
  logic [NUM_PINS-1:0] pol;
  logic [NUM_PINS-1:0] pending;
  logic                gpio_sum;
  logic                cmask;

  gpio_pcmp_regs #(.NUM_PINS(NUM_PINS), .ADDR_W(ADDR_W)) u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .req_i      (reg_req_i),
    .we_i       (reg_we_i),
    .addr_i     (reg_addr_i),
    .wdata_i    (reg_wdata_i),
    .rdata_o    (reg_rdata_o),
    .in_sync_i  (in_sync),
    .gpio_sum_i (gpio_sum),
    .dout_o     (pad_out_o),
    .oe_o       (pad_oe_o),
    .alt_o      (alt_sel_o),
    .pu_o       (pad_pu_o),
    .pd_o       (pad_pd_o),
    .ie_o       (ie),
    .pol_o      (pol),
    .cmask_o    (cmask)
  );

  gpio_pcmp_pad #(.NUM_PINS(NUM_PINS)) u_pad (
    .dout_i    (pad_out_o),
    .oe_i      (pad_oe_o),
    .pu_i      (pad_pu_o),
    .pd_i      (pad_pd_o),
    .ext_lvl_i (pad_in_i),
    .ext_en_i  (pad_ext_en_i),
    .level_o   (pad_level)
  );

  gpio_pcmp_sync #(.WIDTH(NUM_PINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (pad_level),
    .q_o    (in_sync)
  );

  gpio_pcmp_irq #(.NUM_PINS(NUM_PINS)) u_irq (
    .level_i   (in_sync),
    .pol_i     (pol),
    .ie_i      (ie),
    .pending_o (pending),
    .sum_o     (gpio_sum)
  );

  assign irq_o = gpio_sum & cmask;

endmodule

// File: rtl/gpio_pcmp_chk.sv
module gpio_pcmp_chk #(
  parameter int unsigned NUM_PINS = 16
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic [NUM_PINS-1:0] pad_level_i,
  input logic [NUM_PINS-1:0] in_sync_i,
  input logic [NUM_PINS-1:0] ie_i,
  input logic [NUM_PINS-1:0] pending_i,
  input logic                gpio_sum_i,
  input logic                cmask_i,
  input logic                irq_i,
  input logic [31:0]         rdata_i
);

  logic [1:0] since_rst_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 since_rst_q <= '0;
    else if (since_rst_q != 2'd2) since_rst_q <= since_rst_q + 2'd1;
  end

  a_r4_sync_two_edges: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (since_rst_q == 2'd2) |-> (in_sync_i == $past(pad_level_i, 2)));

  a_r6_disabled_never_pending: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pending_i & ~ie_i) == '0);

  a_r7_irq_needs_mask_and_sum: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_i |-> (cmask_i && gpio_sum_i));

  a_r7_pending_reaches_irq: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmask_i && (pending_i != '0)) |-> irq_i);

  a_r1_upper_bits_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rdata_i >> NUM_PINS) == 32'd0);

endmodule

bind gpio_pcmp_top gpio_pcmp_chk #(.NUM_PINS(NUM_PINS)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .pad_level_i (pad_level),
  .in_sync_i   (in_sync),
  .ie_i        (ie),
  .pending_i   (pending),
  .gpio_sum_i  (gpio_sum),
  .cmask_i     (cmask),
  .irq_i       (irq_o),
  .rdata_i     (reg_rdata_o)
);

// File: tb/test_gpio_pcmp_top.sv
`timescale 1ns/1ps
module test_gpio_pcmp_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0;
  logic        we = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [15:0] pad_in = '0;
  logic [15:0] ext_en = '0;

  logic [31:0] rd_a, rd_b;
  logic [15:0] out_a, oe_a, pu_a, pd_a, alt_a;
  logic [4:0]  out_b, oe_b, pu_b, pd_b, alt_b;
  logic        irq_a, irq_b;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #2 clk = ~clk;  // 250 MHz

  gpio_pcmp_top i_gpio_pcmp_top (
    .clk_i(clk), .rst_ni(rst_n), .reg_req_i(req), .reg_we_i(we),
    .reg_addr_i(addr), .reg_wdata_i(wdata), .reg_rdata_o(rd_a),
    .pad_in_i(pad_in), .pad_ext_en_i(ext_en),
    .pad_out_o(out_a), .pad_oe_o(oe_a), .pad_pu_o(pu_a), .pad_pd_o(pd_a),
    .alt_sel_o(alt_a), .irq_o(irq_a)
  );

  gpio_pcmp_top #(.NUM_PINS(5)) i_gpio_pcmp_top_n5 (
    .clk_i(clk), .rst_ni(rst_n), .reg_req_i(req), .reg_we_i(we),
    .reg_addr_i(addr), .reg_wdata_i(wdata), .reg_rdata_o(rd_b),
    .pad_in_i(pad_in[4:0]), .pad_ext_en_i(ext_en[4:0]),
    .pad_out_o(out_b), .pad_oe_o(oe_b), .pad_pu_o(pu_b), .pad_pd_o(pd_b),
    .alt_sel_o(alt_b), .irq_o(irq_b)
  );

  // ---------------- behavioural reference ----------------
  logic [31:0] m_out[2], m_oe[2], m_alt[2], m_pu[2], m_pd[2], m_ie[2], m_pol[2];
  logic [31:0] m_s1[2], m_s2[2];
  logic        m_cm[2];

  function automatic logic [31:0] pmask(int k);
    return (k == 0) ? 32'h0000_FFFF : 32'h0000_001F;
  endfunction

  function automatic logic [31:0] m_level(int k);
    logic [31:0] r = '0;
    for (int i = 0; i < 32; i++) begin
      if (m_oe[k][i])                 r[i] = m_out[k][i];
      else if (i < 16 && ext_en[i])   r[i] = pad_in[i];
      else if (m_pu[k][i])            r[i] = 1'b1;
      else if (m_pd[k][i])            r[i] = 1'b0;
      else                            r[i] = 1'b0;
    end
    return r & pmask(k);
  endfunction

  function automatic logic m_sum(int k);
    return |((m_s2[k] ^ m_pol[k]) & m_ie[k]);
  endfunction

  function automatic logic [31:0] m_read(int k, logic [7:0] a);
    case (a[7:2])
      6'd0: return m_s2[k];
      6'd1: return m_out[k];
      6'd2: return m_oe[k];
      6'd3: return m_alt[k];
      6'd4: return m_pu[k];
      6'd5: return m_pd[k];
      6'd6: return m_ie[k];
      6'd7: return m_pol[k];
      6'd8: return {31'd0, m_cm[k]};
      6'd9: return {31'd0, m_sum(k)};
      default: return 32'd0;
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    for (int k = 0; k < 2; k++) begin
      if (!rst_n) begin
        m_out[k] <= '0; m_oe[k] <= '0; m_alt[k] <= '0; m_pu[k] <= '0;
        m_pd[k] <= '0; m_ie[k] <= '0; m_pol[k] <= '0; m_cm[k] <= 1'b0;
        m_s1[k] <= '0; m_s2[k] <= '0;
      end else begin
        m_s1[k] <= m_level(k);
        m_s2[k] <= m_s1[k];
        if (req && we) begin
          case (addr[7:2])
            6'd1: m_out[k] <= wdata & pmask(k);
            6'd2: m_oe[k]  <= wdata & pmask(k);
            6'd3: m_alt[k] <= wdata & pmask(k);
            6'd4: m_pu[k]  <= wdata & pmask(k);
            6'd5: m_pd[k]  <= wdata & pmask(k);
            6'd6: m_ie[k]  <= wdata & pmask(k);
            6'd7: m_pol[k] <= wdata & pmask(k);
            6'd8: m_cm[k]  <= wdata[0];
            default: ;
          endcase
        end
      end
    end
  end

  task automatic cmp(string tag, logic [31:0] got, logic [31:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s at %0t: got %h expected %h", tag, $time, got, exp);
    end
  endtask

  // per-cycle comparison against the model, away from the active edge
  always @(negedge clk) begin
    if (!done) begin
      cmp("R1 rdata 16-pin", rd_a, m_read(0, addr));
      cmp("R1 rdata 5-pin",  rd_b, m_read(1, addr));
      cmp("R7 irq 16-pin",   32'(irq_a), 32'(m_sum(0) & m_cm[0]));
      cmp("R7 irq 5-pin",    32'(irq_b), 32'(m_sum(1) & m_cm[1]));
      cmp("R3 drive 16-pin", {32'(out_a)}, m_out[0]);
      cmp("R3 oe 16-pin",    32'(oe_a), m_oe[0]);
      cmp("R3 drive 5-pin",  32'(out_b), m_out[1]);
      cmp("R9 pulls 16-pin", {pu_a, pd_a}, {m_pu[0][15:0], m_pd[0][15:0]});
      cmp("R9 alt 16-pin",   32'(alt_a), m_alt[0]);
      cmp("R9 pads 5-pin",   32'({pu_b, pd_b, alt_b}), {17'd0, m_pu[1][4:0], m_pd[1][4:0], m_alt[1][4:0]});
    end
  end

  // ---------------- stimulus ----------------
  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(posedge clk); #1;
    req = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(posedge clk); #1;
    req = 1'b0; we = 1'b0;
  endtask

  task automatic rd_chk(string tag, logic [7:0] a, logic [31:0] ea, logic [31:0] eb);
    @(posedge clk); #1;
    addr = a;
    #1.5;
    cmp(tag, rd_a, ea);
    cmp(tag, rd_b, eb);
  endtask

  task automatic idle(int n);
    repeat (n) @(posedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    idle(3);
    #1;
    // R2: outputs during reset
    cmp("R2 irq in reset", 32'({irq_a, irq_b}), 32'd0);
    cmp("R2 pads in reset", {out_a, oe_a}, 32'd0);
    rst_n = 1'b1;
    // R2: every offset reads zero
    for (int i = 0; i < 10; i++) rd_chk("R2 reset value", 8'(i * 4), 32'd0, 32'd0);

    // R1/R10: width masking
    wr(8'h04, 32'hFFFF_FFFF);
    rd_chk("R1 out masked", 8'h04, 32'h0000_FFFF, 32'h0000_001F);
    rd_chk("R10 5-pin width", 8'h04, 32'h0000_FFFF, 32'h0000_001F);
    // R1: read-only and unmapped offsets
    wr(8'h00, 32'h0000_1234);
    rd_chk("R1 input not writable", 8'h00, 32'd0, 32'd0);
    wr(8'h24, 32'h0000_0001);
    rd_chk("R1 status not writable", 8'h24, 32'd0, 32'd0);
    wr(8'h28, 32'hFFFF_FFFF);
    rd_chk("R1 unmapped reads zero", 8'h28, 32'd0, 32'd0);
    rd_chk("R1 unmapped write harmless", 8'h04, 32'h0000_FFFF, 32'h0000_001F);

    // R3/R4: driven pins read back
    wr(8'h04, 32'h0000_A5A5);
    wr(8'h08, 32'h0000_00FF);
    idle(3);
    rd_chk("R4 readback of driven pins", 8'h00, 32'h0000_00A5, 32'h0000_0005);
    cmp("R3 pad_out", 32'(out_a), 32'h0000_A5A5);
    cmp("R3 pad_oe", 32'(oe_a), 32'h0000_00FF);

    // R5: resolution of undriven pins
    pad_in = 16'hFFFF;
    ext_en = 16'hC000;
    wr(8'h10, 32'h0000_0F00);
    wr(8'h14, 32'h0000_3C00);
    idle(3);
    rd_chk("R5 ext > pull-up > pull-down", 8'h00, 32'h0000_CFA5, 32'h0000_0005);

    // R6/R7: pending and mask gating
    wr(8'h18, 32'h0000_0001);
    idle(1);
    rd_chk("R6 status summary", 8'h24, 32'h1, 32'h1);
    cmp("R7 masked irq low", 32'({irq_a, irq_b}), 32'd0);
    wr(8'h20, 32'h0000_0001);
    idle(1); #1.5;
    cmp("R7 unmasked irq high", 32'({irq_a, irq_b}), 32'h3);

    // R8: re-arm by polarity write, then a level change
    wr(8'h1C, 32'h0000_CFA5);
    idle(1); #1.5;
    cmp("R8 quiet after re-arm", 32'({irq_a, irq_b}), 32'd0);
    rd_chk("R8 status clear", 8'h24, 32'd0, 32'd0);
    wr(8'h04, 32'h0000_A5A4);
    @(posedge clk); #1.5;
    cmp("R8 not yet synchronised", 32'({irq_a, irq_b}), 32'd0);
    idle(2); #1.5;
    cmp("R8 fires on level change", 32'({irq_a, irq_b}), 32'h3);
    // R6: enabling a non-matching pin with enable 0 elsewhere
    wr(8'h18, 32'h0000_0000);
    idle(1); #1.5;
    cmp("R6 disabled pins silent", 32'({irq_a, irq_b}), 32'd0);

    // R9: alternate select and claim of pin 12
    wr(8'h0C, 32'h0000_00F0);
    cmp("R9 alt select", {alt_a, 11'd0, alt_b}, {16'h00F0, 11'd0, 5'h10});
    wr(8'h14, 32'h0000_2C00);
    wr(8'h10, 32'h0000_1F00);
    wr(8'h0C, 32'h0000_00F0 & ~32'h0000_1000);
    cmp("R9 claim pulls", {pu_a, pd_a}, 32'h1F00_2C00);
    idle(3);
    rd_chk("R5 claimed pin pulled up", 8'h00, 32'h0000_DFA4, 32'h0000_0004);

    // R10: wide stimulus does not reach the narrow build
    wr(8'h08, 32'h0000_0000);
    ext_en = 16'hFFE0;
    pad_in = 16'hFFE0;
    wr(8'h10, 32'h0);
    wr(8'h14, 32'h0);
    wr(8'h18, 32'hFFFF_FFE0);
    wr(8'h1C, 32'h0);
    idle(3);
    rd_chk("R10 narrow input", 8'h00, 32'h0000_FFE0, 32'h0);
    rd_chk("R10 narrow enable", 8'h18, 32'h0000_FFE0, 32'h0);
    cmp("R10 narrow irq idle", 32'({irq_a, irq_b}), 32'h2);

    idle(2);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule